// File: doc/BRIEF.md
# Test Instruction Register and Data-Register Selector

This block holds the instruction of a boundary-scan test port and turns it into routing and pin-control decisions. A new instruction is shifted in one bit per test clock from the serial input into a 4-bit shift stage. It becomes active only when the controller pulses the IR update strobe. The active instruction chooses which data register sits in the serial path: a 1-bit bypass flop, a 32-bit identification register, or the boundary register. It also decides whether the device pins are driven by the core or by the boundary update stage.

A separate TAP controller supplies capture, shift and update strobes for the instruction path and for the data path, plus a level that marks an instruction scan. The decoder sorts the active code into one of six instruction kinds: EXTEST, SAMPLE, PRELOAD, INTEST, IDCODE and BYPASS. Loading a new code through the update strobe is the only transition between kinds. Test reset forces IDCODE, or BYPASS when no ID register is built.

The boundary register is modelled as a row of shift flops with an update flop behind each one. The pin multiplexer at its output stands in for the boundary cells.

Top module: `tap_instr_path`

## Requirements
- R1: An IR capture strobe loads the shift stage with 4'b0001, so the first two bits shifted out are 1 then 0, followed by 0, 0.
- R2: During an IR shift, the serial input enters the shift stage at the most significant bit and the least significant bit leaves first. The active instruction changes only on an IR update strobe.
- R3: After test reset the active instruction is IDCODE (HAS_ID=1), so a DR scan with no IR load reads the ID word.
- R4: BYPASS (4'b1111) selects a 1-bit register that captures 0. A DR scan therefore returns a 0 followed by the input delayed by one clock.
- R5: Any code other than 0000, 0001, 0010, 0011 and 0100 behaves as BYPASS.
- R6: IDCODE (4'b0100) selects a 32-bit register that captures {version[3:0], part[15:0], maker[10:0], 1'b1} and shifts it out LSB first.
- R7: SAMPLE (4'b0001) selects the boundary register and captures the pin sample inputs. The pins keep following the core outputs and bs_mode stays 0.
- R8: PRELOAD (4'b0010) shifts and updates the boundary update stage while the pins still follow the core. A later EXTEST drives the preloaded values.
- R9: EXTEST (4'b0000) sets bs_mode to 1, drives the pins from the update stage, and captures the pin sample inputs.
- R10: INTEST (4'b0011) sets bs_mode to 1, drives the pins from the update stage, and captures the core outputs instead of the pin samples.
- R11: tdo carries the IR shift-stage LSB while scan_ir is 1 and the selected data register's LSB otherwise. Exactly one data register is selected at any time.
- R12: DR strobes do not change a data register that is not selected. In particular, the boundary update stage keeps its value through DR scans under BYPASS or IDCODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial test data input |
| scan_ir | input | 1 | 1 during an instruction scan, 0 during a data scan |
| ir_capture | input | 1 | Instruction capture strobe |
| ir_shift | input | 1 | Instruction shift strobe |
| ir_update | input | 1 | Instruction update strobe |
| dr_capture | input | 1 | Data register capture strobe |
| dr_shift | input | 1 | Data register shift strobe |
| dr_update | input | 1 | Data register update strobe |
| bs_sample_in | input | BS_LEN | Values seen at the device pins |
| func_out | input | BS_LEN | Values the core wants on the pins |
| tdo | output | 1 | Serial test data output |
| bs_mode | output | 1 | 1 when pins are driven from the boundary update stage |
| pin_drive | output | BS_LEN | Values driven onto the pins |

## Verification
Every defined code and several undefined codes are loaded. After each load, a 2-bit DR capture is taken with the pin samples and core outputs set to give zero low bits. The resulting signature (00 for the boundary register, 11 for the ID register, 10 for bypass) separates the three registers, and bs_mode separates the pin-driving kinds from the observing ones. Directed scans then give pin samples and core outputs different values. This tells SAMPLE/EXTEST capture apart from INTEST capture, and preloaded data apart from live core data. Update scans under BYPASS and IDCODE show that the boundary update stage is left untouched.

// File: rtl/tapir_pkg.sv
package tapir_pkg;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
    localparam logic [IR_W-1:0] OP_PRELOAD = 4'b0010;
    localparam logic [IR_W-1:0] OP_INTEST  = 4'b0011;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;

    // fixed value loaded at IR capture; low two bits read back as 01
    localparam logic [IR_W-1:0] IR_CAPTURE_VAL = 4'b0001;

    typedef enum logic [2:0] {
        K_EXTEST,
        K_SAMPLE,
        K_PRELOAD,
        K_INTEST,
        K_IDCODE,
        K_BYPASS
    } instr_kind_e;

    typedef struct packed {
        logic sel_bsr;   // boundary register in serial path
        logic sel_id;    // identification register in serial path
        logic sel_byp;   // single bypass flop in serial path
        logic pin_ctrl;  // pins driven from boundary update stage
        logic cap_core;  // boundary capture takes core outputs
    } dec_t;

endpackage

// File: rtl/tap_ir.sv
module tap_ir
    import tapir_pkg::*;
#(
    parameter logic [IR_W-1:0] RESET_CODE = OP_IDCODE
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            capture,
    input  logic            shift,
    input  logic            update,
    output logic            sr_lsb,
    output logic [IR_W-1:0] active
);

    logic [IR_W-1:0] sr_q, sr_d;
    logic [IR_W-1:0] act_d;

    always_comb begin
        sr_d  = sr_q;
        act_d = active;
        if (capture)
            sr_d = IR_CAPTURE_VAL;
        else if (shift)
            sr_d = {tdi, sr_q[IR_W-1:1]};
        if (update)
            act_d = sr_q;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr_q   <= '0;
            active <= RESET_CODE;
        end else begin
            sr_q   <= sr_d;
            active <= act_d;
        end
    end

    assign sr_lsb = sr_q[0];

    assert_ir_capture_R1: assert property (@(posedge tck) disable iff (!trst_n)
        capture |=> (sr_q == IR_CAPTURE_VAL));

    assert_active_hold_R2: assert property (@(posedge tck) disable iff (!trst_n)
        !update |=> $stable(active));

    assert_shift_entry_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (shift && !capture) |=> (sr_q[IR_W-1] == $past(tdi)));

endmodule

// File: rtl/tap_decode.sv
module tap_decode
    import tapir_pkg::*;
#(
    parameter bit HAS_ID = 1'b1
) (
    input  logic [IR_W-1:0] active,
    output dec_t            dec
);

    instr_kind_e kind;

    always_comb begin
        unique case (active)
            OP_EXTEST:  kind = K_EXTEST;
            OP_SAMPLE:  kind = K_SAMPLE;
            OP_PRELOAD: kind = K_PRELOAD;
            OP_INTEST:  kind = K_INTEST;
            OP_IDCODE:  kind = HAS_ID ? K_IDCODE : K_BYPASS;
            default:    kind = K_BYPASS;
        endcase
    end

    always_comb begin
        dec = '0;
        unique case (kind)
            K_EXTEST: begin
                dec.sel_bsr  = 1'b1;
                dec.pin_ctrl = 1'b1;
            end
            K_SAMPLE, K_PRELOAD: begin
                dec.sel_bsr = 1'b1;
            end
            K_INTEST: begin
                dec.sel_bsr  = 1'b1;
                dec.pin_ctrl = 1'b1;
                dec.cap_core = 1'b1;
            end
            K_IDCODE: begin
                dec.sel_id = 1'b1;
            end
            default: begin
                dec.sel_byp = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/tap_dregs.sv
module tap_dregs
    import tapir_pkg::*;
#(
    parameter int          BS_LEN  = 8,
    parameter bit          HAS_ID  = 1'b1,
    parameter logic [31:0] ID_WORD = 32'h0000_0001
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  logic              dr_capture,
    input  logic              dr_shift,
    input  logic              dr_update,
    input  dec_t              dec,
    input  logic [BS_LEN-1:0] bs_sample_in,
    input  logic [BS_LEN-1:0] func_out,
    output logic              dr_tdo,
    output logic [BS_LEN-1:0] bs_upd
);

    localparam int ID_W = 32;

    // bypass flop
    logic byp_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            byp_q <= 1'b0;
        else if (dec.sel_byp && dr_capture)
            byp_q <= 1'b0;
        else if (dec.sel_byp && dr_shift)
            byp_q <= tdi;
    end

    assert_bypass_zero_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (dec.sel_byp && dr_capture) |=> (dr_tdo == 1'b0));

    // identification register
    logic id_lsb;

    generate
        if (HAS_ID) begin : g_id
            logic [ID_W-1:0] id_q;
            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n)
                    id_q <= '0;
                else if (dec.sel_id && dr_capture)
                    id_q <= ID_WORD;
                else if (dec.sel_id && dr_shift)
                    id_q <= {tdi, id_q[ID_W-1:1]};
            end
            assign id_lsb = id_q[0];

            assert_id_capture_R6: assert property (@(posedge tck) disable iff (!trst_n)
                (dec.sel_id && dr_capture) |=> (id_q == ID_WORD));
        end else begin : g_no_id
            assign id_lsb = 1'b0;
        end
    endgenerate

    // boundary register: one shift flop and one update flop per cell
    logic [BS_LEN-1:0] bsr_q;
    logic [BS_LEN-1:0] cap_src;

    assign cap_src = dec.cap_core ? func_out : bs_sample_in;

    generate
        for (genvar c = 0; c < BS_LEN; c++) begin : g_cell
            logic chain_in;
            if (c == BS_LEN - 1) begin : g_head
                assign chain_in = tdi;
            end else begin : g_link
                assign chain_in = bsr_q[c+1];
            end

            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n) begin
                    bsr_q[c]  <= 1'b0;
                    bs_upd[c] <= 1'b0;
                end else begin
                    if (dec.sel_bsr && dr_capture)
                        bsr_q[c] <= cap_src[c];
                    else if (dec.sel_bsr && dr_shift)
                        bsr_q[c] <= chain_in;
                    if (dec.sel_bsr && dr_update)
                        bs_upd[c] <= bsr_q[c];
                end
            end
        end
    endgenerate

    assert_upd_hold_R12: assert property (@(posedge tck) disable iff (!trst_n)
        !(dec.sel_bsr && dr_update) |=> $stable(bs_upd));

    always_comb begin
        if (dec.sel_id)
            dr_tdo = id_lsb;
        else if (dec.sel_bsr)
            dr_tdo = bsr_q[0];
        else
            dr_tdo = byp_q;
    end

endmodule

// File: rtl/tap_instr_path.sv
module tap_instr_path
    import tapir_pkg::*;
#(
    parameter int           BS_LEN = 8,
    parameter bit           HAS_ID = 1'b1,
    parameter logic [3:0]   ID_VER  = 4'h3,
    parameter logic [15:0]  ID_PART = 16'hB00C,
    parameter logic [10:0]  ID_MFR  = 11'h0A5
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  logic              scan_ir,
    input  logic              ir_capture,
    input  logic              ir_shift,
    input  logic              ir_update,
    input  logic              dr_capture,
    input  logic              dr_shift,
    input  logic              dr_update,
    input  logic [BS_LEN-1:0] bs_sample_in,
    input  logic [BS_LEN-1:0] func_out,
    output logic              tdo,
    output logic              bs_mode,
    output logic [BS_LEN-1:0] pin_drive
);

    localparam logic [31:0]     ID_WORD  = {ID_VER, ID_PART, ID_MFR, 1'b1};
    localparam logic [IR_W-1:0] IR_RESET = HAS_ID ? OP_IDCODE : OP_BYPASS;

    logic              ir_lsb;
    logic [IR_W-1:0]   active;
    dec_t              dec;
    logic              dr_tdo;
    logic [BS_LEN-1:0] bs_upd;

    tap_ir #(.RESET_CODE(IR_RESET)) u_ir (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .capture (ir_capture),
        .shift   (ir_shift),
        .update  (ir_update),
        .sr_lsb  (ir_lsb),
        .active  (active)
    );

    tap_decode #(.HAS_ID(HAS_ID)) u_dec (
        .active (active),
        .dec    (dec)
    );

    tap_dregs #(
        .BS_LEN  (BS_LEN),
        .HAS_ID  (HAS_ID),
        .ID_WORD (ID_WORD)
    ) u_dr (
        .tck          (tck),
        .trst_n       (trst_n),
        .tdi          (tdi),
        .dr_capture   (dr_capture),
        .dr_shift     (dr_shift),
        .dr_update    (dr_update),
        .dec          (dec),
        .bs_sample_in (bs_sample_in),
        .func_out     (func_out),
        .dr_tdo       (dr_tdo),
        .bs_upd       (bs_upd)
    );

    assign tdo       = scan_ir ? ir_lsb : dr_tdo;
    assign bs_mode   = dec.pin_ctrl;
    assign pin_drive = dec.pin_ctrl ? bs_upd : func_out;

    assert_one_dr_R11: assert property (@(posedge tck) disable iff (!trst_n)
        $countones({dec.sel_bsr, dec.sel_id, dec.sel_byp}) == 1);

    assert_ir_readback_R11: assert property (@(posedge tck) disable iff (!trst_n)
        (scan_ir && ir_capture) |=> (!scan_ir || tdo));

    assert_mode_needs_bsr_R9: assert property (@(posedge tck) disable iff (!trst_n)
        bs_mode |-> dec.sel_bsr);

endmodule

// File: tb/test_tap_instr_path.sv
`timescale 1ns/1ps
module test_tap_instr_path;

    localparam int BS_LEN = 8;
    localparam logic [31:0] ID_EXP = {4'h3, 16'hB00C, 11'h0A5, 1'b1};

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tdi = 1'b0, scan_ir = 1'b0;
    logic ir_capture = 1'b0, ir_shift = 1'b0, ir_update = 1'b0;
    logic dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0;
    logic [BS_LEN-1:0] bs_sample_in = '0, func_out = '0;
    logic tdo, bs_mode;
    logic [BS_LEN-1:0] pin_drive;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 tck = ~tck;

    tap_instr_path #(.BS_LEN(BS_LEN)) i_tap_instr_path (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .scan_ir(scan_ir),
        .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_update(ir_update),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
        .bs_sample_in(bs_sample_in), .func_out(func_out),
        .tdo(tdo), .bs_mode(bs_mode), .pin_drive(pin_drive)
    );

    // code[3:0], expected bs_mode, 2-bit capture signature
    // signature: 00 boundary, 11 identification, 10 bypass
    localparam logic [6:0] VEC [9] = '{
        {4'b0000, 1'b1, 2'b00},
        {4'b0001, 1'b0, 2'b00},
        {4'b0010, 1'b0, 2'b00},
        {4'b0011, 1'b1, 2'b00},
        {4'b0100, 1'b0, 2'b11},
        {4'b1111, 1'b0, 2'b10},
        {4'b1010, 1'b0, 2'b10},
        {4'b0101, 1'b0, 2'b10},
        {4'b0111, 1'b0, 2'b10}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge tck);
        @(negedge tck);
    endtask

    task automatic load_ir(input logic [3:0] code, input bit do_update, output logic [3:0] seen);
        scan_ir = 1'b1;
        ir_capture = 1'b1;
        tick();
        ir_capture = 1'b0;
        ir_shift = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tdi = code[i];
            seen[i] = tdo;
            tick();
        end
        ir_shift = 1'b0;
        if (do_update) begin
            ir_update = 1'b1;
            tick();
            ir_update = 1'b0;
        end
        scan_ir = 1'b0;
    endtask

    task automatic scan_dr(input logic [63:0] din, input int len, input bit do_update,
                           output logic [63:0] dout);
        dout = '0;
        scan_ir = 1'b0;
        dr_capture = 1'b1;
        tick();
        dr_capture = 1'b0;
        dr_shift = 1'b1;
        for (int i = 0; i < len; i++) begin
            tdi = din[i];
            dout[i] = tdo;
            tick();
        end
        dr_shift = 1'b0;
        if (do_update) begin
            dr_update = 1'b1;
            tick();
            dr_update = 1'b0;
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0]  seen;
        logic [63:0] dout;

        func_out = 8'h5A;
        repeat (3) @(negedge tck);
        trst_n = 1'b1;
        @(negedge tck);

        // reset state
        chk(bs_mode == 1'b0, "R3 reset mode", bs_mode, 0);
        chk(pin_drive == func_out, "R3 reset pins", pin_drive, func_out);
        scan_dr(64'h0, 32, 1'b0, dout);
        chk(dout[31:0] == ID_EXP, "R3 R6 reset selects id", dout[31:0], ID_EXP);

        // table walk over codes
        bs_sample_in = 8'hFC;
        func_out = 8'hFC;
        for (int v = 0; v < 9; v++) begin
            load_ir(VEC[v][6:3], 1'b1, seen);
            chk(seen == 4'b0001, "R1 R11 capture pattern", seen, 4'b0001);
            chk(bs_mode == VEC[v][2], "R9 R10 R5 mode per code", bs_mode, VEC[v][2]);
            scan_dr(64'h3, 2, 1'b0, dout);
            chk(dout[1:0] == VEC[v][1:0], "R5 R11 register signature", dout[1:0], VEC[v][1:0]);
        end

        // bypass delay
        load_ir(4'b1111, 1'b1, seen);
        scan_dr(64'hC5A3, 16, 1'b0, dout);
        chk(dout[15:0] == {16'hC5A3 << 1}, "R4 one-clock bypass delay", dout[15:0], 16'hC5A3 << 1);
        load_ir(4'b1001, 1'b1, seen);
        scan_dr(64'h0F0F, 16, 1'b0, dout);
        chk(dout[15:0] == 16'h1E1E, "R5 undefined acts as bypass", dout[15:0], 16'h1E1E);

        // SAMPLE
        func_out = 8'h5A;
        bs_sample_in = 8'hA6;
        load_ir(4'b0001, 1'b1, seen);
        chk(bs_mode == 1'b0 && pin_drive == 8'h5A, "R7 sample leaves pins", pin_drive, 8'h5A);
        scan_dr(64'h0, 8, 1'b0, dout);
        chk(dout[7:0] == 8'hA6, "R7 sample captures pins", dout[7:0], 8'hA6);

        // PRELOAD then EXTEST
        load_ir(4'b0010, 1'b1, seen);
        scan_dr(64'h3C, 8, 1'b1, dout);
        chk(pin_drive == 8'h5A, "R8 preload keeps core on pins", pin_drive, 8'h5A);
        load_ir(4'b0000, 1'b1, seen);
        chk(bs_mode == 1'b1 && pin_drive == 8'h3C, "R8 R9 extest drives preload", pin_drive, 8'h3C);

        // EXTEST scan
        scan_dr(64'h81, 8, 1'b1, dout);
        chk(dout[7:0] == 8'hA6, "R9 extest captures pin samples", dout[7:0], 8'hA6);
        chk(pin_drive == 8'h81, "R9 extest update drives pins", pin_drive, 8'h81);

        // INTEST
        load_ir(4'b0011, 1'b1, seen);
        chk(bs_mode == 1'b1, "R10 intest mode", bs_mode, 1);
        scan_dr(64'h42, 8, 1'b1, dout);
        chk(dout[7:0] == 8'h5A, "R10 intest captures core", dout[7:0], 8'h5A);
        chk(pin_drive == 8'h42, "R10 intest drives update", pin_drive, 8'h42);

        // unselected registers untouched
        load_ir(4'b1111, 1'b1, seen);
        chk(pin_drive == 8'h5A, "R12 bypass returns pins to core", pin_drive, 8'h5A);
        scan_dr(64'hFF, 8, 1'b1, dout);
        load_ir(4'b0100, 1'b1, seen);
        scan_dr(64'h0, 32, 1'b1, dout);
        chk(dout[31:0] == ID_EXP, "R6 idcode after reload", dout[31:0], ID_EXP);
        load_ir(4'b0000, 1'b1, seen);
        chk(pin_drive == 8'h42, "R12 update stage held", pin_drive, 8'h42);

        // IR shift without update keeps instruction
        load_ir(4'b1111, 1'b0, seen);
        chk(bs_mode == 1'b1, "R2 no update keeps instruction", bs_mode, 1);
        scan_dr(64'h0, 2, 1'b0, dout);
        chk(dout[1:0] == 2'b10, "R2 extest still selected", dout[1:0], 2'b10);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule